// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer with Pulse Accumulator

This block is a general-purpose timer. A single 16-bit up-counter advances on ticks from a divider that sets the count rate to the clock rate divided by 1, 2, 4, and so on up to 128. Four channels share that counter. Software sets each channel up either to latch the counter value when a chosen edge arrives on its input pin, or to change its output pin when the counter reaches a programmed value. When the counter wraps it raises a flag, so software can extend the time range by counting wraps.

The last channel can instead act as a 16-bit pulse accumulator. In event mode it counts edges of a chosen polarity on its pin. In gated mode it counts prescaled ticks while its pin is held at the active level. Input pins pass through a two-flop synchronizer before edge detection. Six event flags are cleared by writing a 1 to them. Each flag has its own enable into a single interrupt line.

Software reaches the block through a simple write port and a combinational read port. The address map is: 0 control, 1 channel mode, 2 compare actions, 3 accumulator control, 4 flags, 5 interrupt enables, 6 counter (read-only), 7 accumulator count, 8 to 11 channel value registers 0 to 3.

Top module: `quad_capture_timer`

## Requirements
- R1: After reset every readable register, the counter, the accumulator, all flags, `cmpOut` and `irq` are zero.
- R2: While control bit 0 (run) is 1, the counter advances once every 2^s clock cycles, where s is control bits [3:1]. The divider is cleared while run is 0, so a run of N enabled cycles adds floor(N / 2^s). While run is 0 the counter holds.
- R3: When the counter steps from 0xFFFF to 0, flag bit 4 is set.
- R4: A channel i with mode bit i at 0 is in capture mode. Its edge select sits at mode bits [5+2i:4+2i]: bit 4+2i picks rising edges and bit 5+2i picks falling edges. A selected edge on `chanPin[i]` loads register 8+i with the counter value present two clock edges after the pin changed, and sets flag bit i.
- R5: An edge that the channel's edge select does not pick changes neither the channel register nor flag bit i.
- R6: A channel with mode bit i at 1 is in compare mode. On the prescaled tick that moves the counter off a value equal to register 8+i, it sets flag bit i and applies the action in compare-action bits [2i+1:2i] to `cmpOut[i]`: 0 no change, 1 toggle, 2 clear, 3 set.
- R7: With accumulator control bit 0 at 1 and bit 1 at 0 (event mode), the accumulator (address 7) goes up by one for each rising edge of `chanPin[3]`, or each falling edge if bit 2 is 1. This happens whether run is set or not.
- R8: With accumulator control bits 0 and 1 at 1 (gated mode), the accumulator goes up by one per prescaled tick while the synchronized `chanPin[3]` is high, or low if bit 2 is 1. It does not count while run is 0.
- R9: While the accumulator is enabled, channel 3 neither captures nor compares, and flag bit 3 stays clear.
- R10: When the accumulator steps from 0xFFFF to 0, flag bit 5 is set.
- R11: Writing to address 4 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R12: `irq` is 1 exactly when some flag is set whose enable bit at address 5 is also 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data at `addr` |
| chanPin | input | 4 | Channel input pins (pin 3 also feeds the accumulator) |
| cmpOut | output | 4 | Compare output pins |
| statusFlags | output | 6 | Flags: [3:0] channels, [4] counter wrap, [5] accumulator wrap |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each pin level lasts at least one full clock cycle, so the synchronizer sees every change. They also assume that a write is a one-cycle pulse whose address and data are steady around the edge. The stimulus changes pins only on falling clock edges and holds each level for three or more cycles. It performs writes through a task that raises `wrEn` for exactly one rising edge. Random capture, compare and accumulator runs draw their channels, edge selects, actions and delays from a seeded generator, inside these limits.

// File: rtl/qct_pkg.sv
package qct_pkg;
  parameter int CNT_W     = 16;
  parameter int NCH       = 4;
  parameter int PS_STAGES = 7;
  parameter int ADDR_W    = 4;

  localparam int PSEL_W  = $clog2(PS_STAGES + 1);
  localparam int NFLAG   = NCH + 2;
  localparam int CH_BASE = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OCACT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PACTL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_PACNT = ADDR_W'(7);

  typedef enum logic [1:0] {OC_NONE, OC_TOGGLE, OC_CLEAR, OC_SET} ocAct_e;

  typedef struct packed {
    logic              run;
    logic [PSEL_W-1:0] psel;
    logic [NCH-1:0]    isCmp;
    logic [2*NCH-1:0]  edgeSel;
    logic [2*NCH-1:0]  ocAct;
    logic              paEn;
    logic              paGated;
    logic              paInv;
  } cfg_t;

  typedef struct packed {
    logic [NCH-1:0]   loadChan;
    logic             loadPa;
    logic [CNT_W-1:0] data;
  } strobe_t;

  typedef struct packed {
    logic [NCH-1:0] chHit;
    logic           cntWrap;
    logic           paWrap;
  } evt_t;
endpackage

// File: rtl/qct_datapath.sv
module qct_datapath
  import qct_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  cfg_t                      cfg,
  input  strobe_t                   stb,
  input  logic [NCH-1:0]            pinIn,
  output evt_t                      evt,
  output logic [CNT_W-1:0]          cntVal,
  output logic [CNT_W-1:0]          paVal,
  output logic [NCH-1:0][CNT_W-1:0] chanVal,
  output logic [NCH-1:0]            ocOut
);
  logic [PS_STAGES-1:0] divCnt;
  logic [PS_STAGES-1:0] divMask;
  logic                 tick;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     paCnt;
  logic [NCH-1:0]       sync1, sync2, prevS, rise, fall, edgeHit, chHitV;
  logic                 paStep;

  // prescaler: divider runs only while enabled, cleared when stopped
  assign divMask = (PS_STAGES'(1) << cfg.psel) - PS_STAGES'(1);
  assign tick    = cfg.run && ((divCnt & divMask) == divMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      cnt    <= '0;
    end else begin
      divCnt <= cfg.run ? divCnt + PS_STAGES'(1) : '0;
      if (tick) cnt <= cnt + CNT_W'(1);
    end
  end

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      prevS <= '0;
    end else begin
      sync1 <= pinIn;
      sync2 <= sync1;
      prevS <= sync2;
    end
  end

  assign rise = sync2 & ~prevS;
  assign fall = ~sync2 & prevS;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam bit IS_LAST = (i == NCH - 1);
    logic             chActive, capHit, cmpHit, ocQ;
    logic [CNT_W-1:0] valQ;

    assign edgeHit[i] = (cfg.edgeSel[2*i] & rise[i]) | (cfg.edgeSel[2*i+1] & fall[i]);
    assign chActive   = !(IS_LAST && cfg.paEn);
    assign capHit     = chActive && !cfg.isCmp[i] && edgeHit[i];
    assign cmpHit     = chActive && cfg.isCmp[i] && tick && (cnt == valQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valQ <= '0;
        ocQ  <= 1'b0;
      end else begin
        if (capHit)               valQ <= cnt;
        else if (stb.loadChan[i]) valQ <= stb.data;
        if (cmpHit) begin
          case (ocAct_e'(cfg.ocAct[2*i +: 2]))
            OC_TOGGLE: ocQ <= ~ocQ;
            OC_CLEAR:  ocQ <= 1'b0;
            OC_SET:    ocQ <= 1'b1;
            default:   ocQ <= ocQ;
          endcase
        end
      end
    end

    assign chHitV[i]  = capHit | cmpHit;
    assign chanVal[i] = valQ;
    assign ocOut[i]   = ocQ;
  end

  // pulse accumulator on the last channel's pin
  assign paStep = cfg.paEn &&
                  (cfg.paGated ? (tick && (sync2[NCH-1] ^ cfg.paInv))
                               : (cfg.paInv ? fall[NCH-1] : rise[NCH-1]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           paCnt <= '0;
    else if (stb.loadPa) paCnt <= stb.data;
    else if (paStep)     paCnt <= paCnt + CNT_W'(1);
  end

  always_comb begin
    evt.chHit   = chHitV;
    evt.cntWrap = tick && (cnt == '1);
    evt.paWrap  = paStep && !stb.loadPa && (paCnt == '1);
  end

  assign cntVal = cnt;
  assign paVal  = paCnt;

  // R2: a stopped counter never moves
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |=> $stable(cntVal));
  // R3: a reported wrap leaves the counter at zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    evt.cntWrap |=> (cntVal == '0));
  // R6: compare pins only move on a channel event
  a_r6_oc_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(|evt.chHit) |=> $stable(ocOut));
  // R7: disabled accumulator holds unless loaded
  a_r7_pa_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.paEn && !stb.loadPa) |=> $stable(paVal));
endmodule

// File: rtl/qct_ctrl.sv
module qct_ctrl
  import qct_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wrData,
  input  evt_t                      evt,
  input  logic [CNT_W-1:0]          cntVal,
  input  logic [CNT_W-1:0]          paVal,
  input  logic [NCH-1:0][CNT_W-1:0] chanVal,
  output cfg_t                      cfg,
  output strobe_t                   stb,
  output logic [CNT_W-1:0]          rdData,
  output logic [NFLAG-1:0]          flags,
  output logic                      irq
);
  logic [NFLAG-1:0] ien, setV, clrV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
      ien <= '0;
    end else if (wrEn) begin
      case (addr)
        A_CTRL: begin
          cfg.run  <= wrData[0];
          cfg.psel <= wrData[PSEL_W:1];
        end
        A_MODE: begin
          cfg.isCmp   <= wrData[NCH-1:0];
          cfg.edgeSel <= wrData[NCH +: 2*NCH];
        end
        A_OCACT: cfg.ocAct <= wrData[2*NCH-1:0];
        A_PACTL: begin
          cfg.paEn    <= wrData[0];
          cfg.paGated <= wrData[1];
          cfg.paInv   <= wrData[2];
        end
        A_IEN:   ien <= wrData[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  assign setV = {evt.paWrap, evt.cntWrap, evt.chHit};
  assign clrV = (wrEn && addr == A_FLAGS) ? wrData[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrV) | setV;
  end

  assign irq = |(flags & ien);

  always_comb begin
    for (int i = 0; i < NCH; i++)
      stb.loadChan[i] = wrEn && (addr == ADDR_W'(CH_BASE + i));
    stb.loadPa = wrEn && (addr == A_PACNT);
    stb.data   = wrData;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:  rdData = CNT_W'({cfg.psel, cfg.run});
      A_MODE:  rdData = CNT_W'({cfg.edgeSel, cfg.isCmp});
      A_OCACT: rdData = CNT_W'(cfg.ocAct);
      A_PACTL: rdData = CNT_W'({cfg.paInv, cfg.paGated, cfg.paEn});
      A_FLAGS: rdData = CNT_W'(flags);
      A_IEN:   rdData = CNT_W'(ien);
      A_COUNT: rdData = cntVal;
      A_PACNT: rdData = paVal;
      default:
        for (int i = 0; i < NCH; i++)
          if (addr == ADDR_W'(CH_BASE + i)) rdData = chanVal[i];
    endcase
  end

  // R4: every channel event is reflected in its flag one cycle later
  a_r4_flag_follows_hit: assert property (@(posedge clk) disable iff (!rstN)
    (|evt.chHit) |=> ((flags[NCH-1:0] & $past(evt.chHit)) == $past(evt.chHit)));
  // R11: a write-one clears the counter-wrap flag when no wrap competes
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FLAGS && wrData[NCH] && !evt.cntWrap) |=> !flags[NCH]);
endmodule

// File: rtl/quad_capture_timer.sv
module quad_capture_timer
  import qct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [NCH-1:0]    chanPin,
  output logic [NCH-1:0]    cmpOut,
  output logic [NFLAG-1:0]  statusFlags,
  output logic              irq
);
  cfg_t                      cfg;
  strobe_t                   stb;
  evt_t                      evt;
  logic [CNT_W-1:0]          cntVal, paVal;
  logic [NCH-1:0][CNT_W-1:0] chanVal;

  qct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evt(evt), .cntVal(cntVal), .paVal(paVal), .chanVal(chanVal),
    .cfg(cfg), .stb(stb), .rdData(rdData), .flags(statusFlags), .irq(irq)
  );

  qct_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .pinIn(chanPin),
    .evt(evt), .cntVal(cntVal), .paVal(paVal), .chanVal(chanVal), .ocOut(cmpOut)
  );
endmodule

// File: tb/quad_capture_timer_test.sv
module quad_capture_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  pinV = '0;
  logic [3:0]  cmpOut;
  logic [5:0]  statusFlags;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  quad_capture_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chanPin(pinV), .cmpOut(cmpOut),
    .statusFlags(statusFlags), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [15:0] expCount(input logic [15:0] c0, input int n, input int s);
    return c0 + 16'(n >> s);
  endfunction

  function automatic logic ocNext(input logic old, input int act);
    case (act)
      1: return ~old;
      2: return 1'b0;
      3: return 1'b1;
      default: return old;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c, old, p0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 cmpOut", cmpOut, 0);
    chk("R1 flags", statusFlags, 0);
    chk("R1 irq", irq, 0);

    // R2 prescaler: directed extremes then random
    for (int it = 0; it < 10; it++) begin
      int s, k;
      s = (it < 3) ? ((it == 0) ? 0 : (it == 1) ? 3 : 7) : int'($urandom % 8);
      k = 1 + int'($urandom % 300);
      rd(4'd6, c);
      wr(4'd0, 16'((s << 1) | 1));
      idle(k);
      wr(4'd0, 16'(s << 1));
      rd(4'd6, v);
      chk($sformatf("R2 sel=%0d n=%0d", s, k + 1), v, expCount(c, k + 1, s));
    end
    rd(4'd6, c);
    idle(20);
    rd(4'd6, v);
    chk("R2 hold while stopped", v, c);

    // R3 overflow, R11 write-one-to-clear, R12 enable gating
    rd(4'd6, c);
    begin
      int n;
      n = 65536 - int'(c);
      wr(4'd0, 16'h0001);
      idle(n - 2);
      wr(4'd0, 16'h0000);
    end
    rd(4'd6, v);
    chk("R3 count at top", v, 16'hFFFF);
    chk("R3 no flag before wrap", statusFlags[4], 0);
    wr(4'd5, 16'h0010);
    chk("R12 irq low without flag", irq, 0);
    wr(4'd0, 16'h0001);
    wr(4'd0, 16'h0000);
    rd(4'd6, v);
    chk("R3 wrapped to zero", v, 0);
    chk("R3 wrap flag", statusFlags[4], 1);
    chk("R12 irq on enabled flag", irq, 1);
    wr(4'd4, 16'h0000);
    chk("R11 zero write keeps flag", statusFlags[4], 1);
    wr(4'd4, 16'h0010);
    chk("R11 one write clears flag", statusFlags[4], 0);
    chk("R12 irq drops", irq, 0);
    wr(4'd5, 16'h0000);

    // R4/R5 capture with random channels, edge selects and pin directions
    wr(4'd0, 16'h0001);
    for (int it = 0; it < 24; it++) begin
      int ch, es;
      logic rising, hit;
      ch = int'($urandom % 4);
      es = (it < 8) ? (it % 4) : int'($urandom % 4);
      wr(4'd1, 16'(es << (4 + 2 * ch)));
      wr(4'd4, 16'h003F);
      rd(4'(8 + ch), old);
      rd(4'd6, c);
      pinV[ch] = ~pinV[ch];
      rising = pinV[ch];
      hit = rising ? es[0] : es[1];
      idle(3);
      rd(4'(8 + ch), v);
      if (hit) begin
        chk($sformatf("R4 capture ch%0d es=%0d", ch, es), v, c + 16'd2);
        chk($sformatf("R4 flag ch%0d", ch), statusFlags[ch], 1);
      end else begin
        chk($sformatf("R5 ignored ch%0d es=%0d", ch, es), v, old);
        chk($sformatf("R5 no flag ch%0d", ch), statusFlags[ch], 0);
      end
      idle(2);
    end

    // R6 compare with random actions and distances
    wr(4'd1, 16'h0000);
    for (int it = 0; it < 12; it++) begin
      int ch, act, d;
      logic o;
      ch  = int'($urandom % 4);
      act = (it < 4) ? it : int'($urandom % 4);
      d   = 6 + int'($urandom % 30);
      wr(4'd2, 16'(act << (2 * ch)));
      wr(4'd4, 16'h003F);
      rd(4'd6, c);
      wr(4'(8 + ch), c + 16'(d));
      wr(4'd1, 16'(1 << ch));
      o = cmpOut[ch];
      idle(d - 2);
      chk($sformatf("R6 before match ch%0d", ch), cmpOut[ch], o);
      chk($sformatf("R6 no early flag ch%0d", ch), statusFlags[ch], 0);
      idle(1);
      chk($sformatf("R6 action ch%0d act=%0d", ch, act), cmpOut[ch], ocNext(o, act));
      chk($sformatf("R6 flag ch%0d", ch), statusFlags[ch], 1);
      wr(4'd1, 16'h0000);
    end

    // R7 event mode with counter stopped, R9 channel 3 taken over
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h0C00);
    for (int it = 0; it < 4; it++) begin
      int pol, n;
      pol = it % 2;
      n = 1 + int'($urandom % 10);
      p0 = 16'($urandom);
      wr(4'd3, 16'(1 | (pol << 2)));
      wr(4'd7, p0);
      wr(4'd4, 16'h003F);
      for (int t = 0; t < 2 * n; t++) begin
        pinV[3] = ~pinV[3];
        idle(3);
      end
      idle(2);
      rd(4'd7, v);
      chk($sformatf("R7 events pol=%0d n=%0d", pol, n), v, p0 + 16'(n));
      chk("R9 channel 3 silent", statusFlags[3], 0);
    end

    // R8 gated mode
    wr(4'd0, 16'h0001);
    for (int it = 0; it < 4; it++) begin
      int pol, h;
      pol = it % 2;
      h = 1 + int'($urandom % 40);
      pinV[3] = 1'(pol);
      idle(4);
      wr(4'd3, 16'(3 | (pol << 2)));
      wr(4'd7, 16'h0000);
      pinV[3] = ~1'(pol);
      idle(h);
      pinV[3] = 1'(pol);
      idle(4);
      rd(4'd7, v);
      chk($sformatf("R8 gated pol=%0d h=%0d", pol, h), v, 16'(h));
      wr(4'd0, 16'h0000);
      pinV[3] = ~1'(pol);
      idle(10);
      pinV[3] = 1'(pol);
      idle(4);
      rd(4'd7, v);
      chk("R8 no count when stopped", v, 16'(h));
      wr(4'd0, 16'h0001);
    end

    // R10 accumulator wrap, R12 enable gating
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'h0001);
    wr(4'd5, 16'h0020);
    wr(4'd4, 16'h003F);
    wr(4'd7, 16'hFFFE);
    for (int t = 0; t < 2; t++) begin pinV[3] = ~pinV[3]; idle(3); end
    idle(2);
    rd(4'd7, v);
    chk("R10 accumulator at top", v, 16'hFFFF);
    chk("R10 no flag yet", statusFlags[5], 0);
    for (int t = 0; t < 2; t++) begin pinV[3] = ~pinV[3]; idle(3); end
    idle(2);
    rd(4'd7, v);
    chk("R10 accumulator wrapped", v, 0);
    chk("R10 wrap flag", statusFlags[5], 1);
    chk("R12 irq from accumulator", irq, 1);
    wr(4'd5, 16'h0000);
    chk("R12 irq masked", irq, 0);
    chk("R12 flag still held", statusFlags[5], 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule